// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

The controller gathers a parameterised number of interrupt request lines (up to the 32-bit data width) into a latched status vector. Each line is fixed at build time as either edge-sensitive, where a rising transition is remembered until software clears it, or level-sensitive, where the status bit follows a high input. An enable vector masks the latched status into a pending vector. A single interrupt line to the processor is raised while anything is pending and both bits of a two-bit master control register are set.

Software reaches the block through a plain synchronous register port: a byte address, a one-cycle write strobe with write data, and combinational read data for the address currently presented. Apart from a full-word enable write, the enable vector can be changed bit by bit through write-one-to-set and write-one-to-clear aliases. Latched requests are cleared through a write-one-to-clear acknowledge register. A vector register returns the number of the lowest-numbered pending line, which has the highest priority, or all ones when nothing is pending. A handler therefore reads the vector, services that line, acknowledges it and reads again until it sees all ones.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and master registers read zero, `irq_out` is low and the vector register reads 0xFFFFFFFF. The core leaves reset on the third rising clock edge after `rst_n` rises.
- R2: The register is selected by address bits [4:2] and address bits [1:0] are ignored: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master. Writes to status, pending and vector change nothing. Acknowledge, set-enable and clear-enable read as zero.
- R3: A line whose bit in `EDGE_KIND` is 1 sets its status bit on the clock edge where the input is high and its registered copy from the previous cycle is low. The bit stays set after the input falls.
- R4: A line whose `EDGE_KIND` bit is 0 sets its status bit on every edge where the input is high. An acknowledge of that line clears it at the acknowledge edge, and if the input is still high the bit is set again one edge later.
- R5: Writing the acknowledge register clears each status bit whose write-data bit is 1 and leaves the others alone. Writing 0xFFFFFFFF clears all latched edge requests. For an edge line, a rising edge in the same cycle as its acknowledge keeps the bit set.
- R6: Writing the enable register loads the enable vector from write data. Writing zero disables every line.
- R7: A write to set-enable ORs the write data into the enable vector. A write to clear-enable clears the enable bits where write data is 1. Zero bits leave enables unchanged in both cases.
- R8: The pending register reads as status AND enable.
- R9: The vector register reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when the pending vector is zero.
- R10: The master register holds write-data bits [1:0], with bit 0 the master enable and bit 1 the output enable. It reads back exactly those two bits, and bits [31:2] read zero.
- R11: `irq_out` is high exactly when the pending vector is non-zero and both master register bits are 1.
- R12: Status, pending and enable bits at positions N_SRC and above always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the register at `bus_addr` (combinational) |
| irq_in | input | N_SRC | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that the request lines and the register port are synchronous to `clk`, with any resynchronisation done upstream, and that a write is held for exactly one cycle with address and data stable around the edge. They also assume that the properties only matter once the internal synchronised reset has released. The bench keeps within these limits by changing every input 2 ns after a rising edge, never on the edge itself. It holds `bus_we` for a single cycle per directed write. Its random phase draws a new address, strobe, data and input pattern once per cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Byte address width of the register port and position of the word select.
  localparam int unsigned REG_ADDR_W = 5;
  localparam int unsigned SEL_LSB    = 2;
  localparam int unsigned SEL_W      = 3;

  // Word index of each register; the index times four is the byte offset.
  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_ENSET  = 3'd4,
    SEL_ENCLR  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  // Bit positions inside the master register.
  localparam int unsigned MST_ON_BIT  = 0;
  localparam int unsigned MST_OUT_BIT = 1;
  localparam int unsigned MST_W       = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_src_sense.sv
module irq_src_sense #(
  parameter int unsigned N_SRC     = 32,
  parameter int unsigned KIND_W    = 32,
  parameter logic [KIND_W-1:0] EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_now,
  input  logic [N_SRC-1:0] req_prev,
  input  logic [N_SRC-1:0] ack_bits,
  output logic [N_SRC-1:0] status_q
);

  localparam logic [N_SRC-1:0] EDGE_MASK = EDGE_KIND[N_SRC-1:0];

  logic [N_SRC-1:0] status_d;
  logic             status_ce;
  logic             unused_prev;

  // Level lines never look at the registered copy of their input.
  assign unused_prev = ^(req_prev & ~EDGE_MASK);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      logic rise;
      assign rise        = req_now[g] & ~req_prev[g];
      // A fresh edge wins over an acknowledge in the same cycle.
      assign status_d[g] = (status_q[g] & ~ack_bits[g]) | rise;
    end else begin : g_level
      // Acknowledge wins; a still-high input sets the bit again next edge.
      assign status_d[g] = (status_q[g] | req_now[g]) & ~ack_bits[g];
    end
  end

  assign status_ce = (status_d != status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_ce) begin
      status_q <= status_d;
    end
  end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned N_REQ = 32,
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top down so the lowest set bit is the last one taken.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_SRC     = 32,
  parameter logic [DATA_W-1:0] EDGE_KIND = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [N_SRC-1:0]      irq_in,
  output logic                  irq_out
);

  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  // ---------------------------------------------------------------- reset
  logic rst_core_n;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  // --------------------------------------------------------------- decode
  reg_sel_e         sel;
  logic             wr_enable, wr_enset, wr_enclr, wr_ack, wr_master;
  logic [N_SRC-1:0] wbits;
  logic             unused_bus;

  assign sel        = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
  assign wbits      = bus_wdata[N_SRC-1:0];
  assign unused_bus = ^{bus_addr[SEL_LSB-1:0], bus_wdata};

  always_comb begin
    wr_enable = 1'b0;
    wr_enset  = 1'b0;
    wr_enclr  = 1'b0;
    wr_ack    = 1'b0;
    wr_master = 1'b0;
    if (bus_we) begin
      unique case (sel)
        SEL_ENABLE: wr_enable = 1'b1;
        SEL_ENSET:  wr_enset  = 1'b1;
        SEL_ENCLR:  wr_enclr  = 1'b1;
        SEL_ACK:    wr_ack    = 1'b1;
        SEL_MASTER: wr_master = 1'b1;
        default:    ;
      endcase
    end
  end

  // ------------------------------------------------- input history register
  logic [N_SRC-1:0] in_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      in_q <= '0;
    end else begin
      in_q <= irq_in;
    end
  end

  // --------------------------------------------------------------- status
  logic [N_SRC-1:0] ack_bits;
  logic [N_SRC-1:0] status_q;

  assign ack_bits = wr_ack ? wbits : '0;

  irq_src_sense #(
    .N_SRC     (N_SRC),
    .KIND_W    (DATA_W),
    .EDGE_KIND (EDGE_KIND)
  ) u_sense (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req_now  (irq_in),
    .req_prev (in_q),
    .ack_bits (ack_bits),
    .status_q (status_q)
  );

  // --------------------------------------------------------------- enable
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] enable_d;
  logic             enable_ce;

  assign enable_ce = wr_enable | wr_enset | wr_enclr;

  always_comb begin
    enable_d = enable_q;
    if (wr_enable) begin
      enable_d = wbits;
    end else if (wr_enset) begin
      enable_d = enable_q | wbits;
    end else if (wr_enclr) begin
      enable_d = enable_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      enable_q <= '0;
    end else if (enable_ce) begin
      enable_q <= enable_d;
    end
  end

  // --------------------------------------------------------------- master
  logic [MST_W-1:0] master_q;
  logic [MST_W-1:0] master_d;

  assign master_d = bus_wdata[MST_W-1:0];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      master_q <= '0;
    end else if (wr_master) begin
      master_q <= master_d;
    end
  end

  // ------------------------------------------------------ pending, vector
  logic [N_SRC-1:0] pend;
  logic             vec_found;
  logic [IDX_W-1:0] vec_idx;

  assign pend = status_q & enable_q;

  irq_lowest_enc #(.N_REQ(N_SRC)) u_enc (
    .req   (pend),
    .found (vec_found),
    .idx   (vec_idx)
  );

  assign irq_out = (|pend) & master_q[MST_ON_BIT] & master_q[MST_OUT_BIT];

  // ----------------------------------------------------------- read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_STATUS: bus_rdata[N_SRC-1:0] = status_q;
      SEL_PEND:   bus_rdata[N_SRC-1:0] = pend;
      SEL_ENABLE: bus_rdata[N_SRC-1:0] = enable_q;
      SEL_VECTOR: bus_rdata = vec_found ? DATA_W'(vec_idx) : '1;
      SEL_MASTER: bus_rdata[MST_W-1:0] = master_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_SRC     = 32,
  parameter logic [DATA_W-1:0] EDGE_KIND = '0,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                  clk,
  input logic                  rst_core_n,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic                  bus_we,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [N_SRC-1:0]      irq_in,
  input logic [N_SRC-1:0]      in_q,
  input logic [N_SRC-1:0]      status_q,
  input logic [N_SRC-1:0]      enable_q,
  input logic [MST_W-1:0]      master_q,
  input logic                  vec_found,
  input logic [IDX_W-1:0]      vec_idx,
  input logic                  irq_out
);

  localparam logic [N_SRC-1:0] EDGE_M  = EDGE_KIND[N_SRC-1:0];
  localparam logic [N_SRC-1:0] LEVEL_M = ~EDGE_KIND[N_SRC-1:0];

  logic [SEL_W-1:0] csel;
  logic [N_SRC-1:0] cack;
  logic [N_SRC-1:0] crise;
  logic [N_SRC-1:0] cpend;

  assign csel  = bus_addr[SEL_LSB +: SEL_W];
  assign cack  = (bus_we && csel == SEL_ACK) ? bus_wdata[N_SRC-1:0] : '0;
  assign crise = irq_in & ~in_q;
  assign cpend = status_q & enable_q;

  // R5: an acknowledged edge line without a new edge is clear next cycle
  a_r5_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|(cack & EDGE_M)) |=> ((status_q & $past(cack & EDGE_M & ~crise)) == '0));

  // R4: a high level line not acknowledged is set on the next cycle
  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|(irq_in & LEVEL_M & ~cack)) |=>
      ((status_q & $past(irq_in & LEVEL_M & ~cack)) == $past(irq_in & LEVEL_M & ~cack)));

  // R7: bits written to set-enable are enabled afterwards
  a_r7_set_enable: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && csel == SEL_ENSET) |=>
      ((enable_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  // R10: master register captures the two written bits
  a_r10_master_capture: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && csel == SEL_MASTER) |=> (master_q == $past(bus_wdata[MST_W-1:0])));

  // R9: the reported index is pending and nothing below it is
  a_r9_lowest_index: assert property (@(posedge clk) disable iff (!rst_core_n)
    vec_found |-> (cpend[vec_idx] &&
      ((cpend & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));

  // R9: nothing pending reads all ones at the vector address
  a_r9_none_all_ones: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpend == '0 && csel == SEL_VECTOR) |-> (bus_rdata == '1));

  // R11: no interrupt while either master bit is clear
  a_r11_gated_out: assert property (@(posedge clk) disable iff (!rst_core_n)
    (master_q != 2'b11) |-> !irq_out);

endmodule

bind irq_vec_ctrl irq_vec_chk #(
  .DATA_W    (DATA_W),
  .N_SRC     (N_SRC),
  .EDGE_KIND (EDGE_KIND)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_in     (irq_in),
  .in_q       (in_q),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .master_q   (master_q),
  .vec_found  (vec_found),
  .vec_idx    (vec_idx),
  .irq_out    (irq_out)
);

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;

  localparam int          N    = 12;
  localparam logic [31:0] KIND = 32'h0000_0C33; // edge: 0,1,4,5,10,11
  localparam logic [31:0] VALID = 32'h0000_0FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in;
  logic        irq_out;

  int    n_checks = 0;
  int    n_err    = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  irq_vec_ctrl #(.DATA_W(32), .N_SRC(N), .EDGE_KIND(KIND)) i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  // ------------------------------------------------ behavioural reference
  logic [31:0] m_st, m_en, m_inq;
  logic [1:0]  m_mst;
  int          m_rcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_inq = 0; m_mst = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt = m_rcnt + 1;
    end else begin
      logic [31:0] ack, inw;
      int sel;
      sel = int'(bus_addr[4:2]);
      inw = 32'(irq_in);
      ack = (bus_we && sel == 3) ? bus_wdata : 32'h0;
      for (int i = 0; i < N; i++) begin
        if (KIND[i]) m_st[i] = (m_st[i] && !ack[i]) || (inw[i] && !m_inq[i]);
        else         m_st[i] = (m_st[i] || inw[i]) && !ack[i];
      end
      if (bus_we) begin
        case (sel)
          2: m_en = bus_wdata & VALID;
          4: m_en = (m_en | bus_wdata) & VALID;
          5: m_en = m_en & ~bus_wdata;
          7: m_mst = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_inq = inw;
    end
  end

  function automatic logic [31:0] exp_vec();
    logic [31:0] p = m_st & m_en;
    for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a[4:2])
      3'd0: return m_st;
      3'd1: return m_st & m_en;
      3'd2: return m_en;
      3'd6: return exp_vec();
      3'd7: return {30'h0, m_mst};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare against the model in the middle of every cycle.
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, bus_rdata, exp_read(bus_addr));
      chk({cur_req, "/R11 irq_out"}, 32'(irq_out),
          32'(((m_st & m_en) != 0) && m_mst == 2'b11));
    end
  end

  // --------------------------------------------------------------- tasks
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd_exp(logic [4:0] a, logic [31:0] e, string tag);
    @(posedge clk); #2;
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, e);
  endtask

  task automatic set_in(logic [N-1:0] v);
    @(posedge clk); #2;
    irq_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // ------------------------------------------------------------ watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  // ------------------------------------------------------------ stimulus
  initial begin
    rst_n = 1'b0; bus_addr = 5'h18; bus_we = 1'b0; bus_wdata = 0; irq_in = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(3);

    cur_req = "R1";
    rd_exp(5'h18, 32'hFFFF_FFFF, "R1 vector after reset");
    rd_exp(5'h00, 32'h0, "R1 status after reset");
    rd_exp(5'h1C, 32'h0, "R1 master after reset");
    chk("R1 irq_out after reset", 32'(irq_out), 32'h0);

    cur_req = "R10";
    wr(5'h1C, 32'h3);
    rd_exp(5'h1C, 32'h3, "R10 master readback 3");
    wr(5'h1C, 32'hFFFF_FFFE);
    rd_exp(5'h1C, 32'h2, "R10 master readback drops upper bits");
    wr(5'h1C, 32'h3);

    cur_req = "R7";
    wr(5'h08, 32'h0F0);
    rd_exp(5'h08, 32'h0F0, "R6 enable write");
    wr(5'h10, 32'h003);
    rd_exp(5'h08, 32'h0F3, "R7 set-enable");
    wr(5'h14, 32'h030);
    rd_exp(5'h08, 32'h0C3, "R7 clear-enable");
    rd_exp(5'h10, 32'h0, "R7 set alias reads zero");
    rd_exp(5'h14, 32'h0, "R7 clear alias reads zero");
    cur_req = "R6";
    wr(5'h08, 32'h0);
    rd_exp(5'h08, 32'h0, "R6 enable zero disables all");
    cur_req = "R12";
    wr(5'h08, 32'hFFFF_FFFF);
    rd_exp(5'h08, 32'h0000_0FFF, "R12 upper enable bits zero");

    cur_req = "R3";
    set_in(12'h002);
    idle(2);
    set_in(12'h000);
    rd_exp(5'h00, 32'h2, "R3 edge latched after input fell");
    rd_exp(5'h18, 32'h1, "R9 vector of single edge");
    chk("R11 irq_out with pending", 32'(irq_out), 32'h1);
    cur_req = "R5";
    wr(5'h0C, 32'h0);
    rd_exp(5'h00, 32'h2, "R5 ack of zero bits no effect");
    wr(5'h0C, 32'h2);
    rd_exp(5'h00, 32'h0, "R5 ack clears edge");

    cur_req = "R4";
    set_in(12'h004);
    idle(1);
    @(posedge clk); #2;
    bus_addr = 5'h0C; bus_we = 1'b1; bus_wdata = 32'h4;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = 5'h00;
    @(negedge clk);
    chk("R4 level cleared at ack", bus_rdata & 32'h4, 32'h0);
    @(negedge clk);
    chk("R4 level re-set while high", bus_rdata & 32'h4, 32'h4);
    set_in(12'h000);
    wr(5'h0C, 32'h4);

    cur_req = "R5";
    set_in(12'h001);
    set_in(12'h000);
    @(posedge clk); #2;
    bus_addr = 5'h0C; bus_we = 1'b1; bus_wdata = 32'h1; irq_in = 12'h001;
    @(posedge clk); #2;
    bus_we = 1'b0;
    rd_exp(5'h00, 32'h1, "R5 edge in ack cycle survives");
    wr(5'h0C, 32'hFFFF_FFFF);
    set_in(12'h000);
    rd_exp(5'h00, 32'h0, "R5 ack all ones clears all");

    cur_req = "R9";
    wr(5'h08, 32'h0);
    wr(5'h10, 32'hE20);
    set_in(12'h220); // bits 5 (edge) and 9 (level)
    set_in(12'h200);
    rd_exp(5'h04, 32'h220, "R8 pending equals status and enable");
    rd_exp(5'h18, 32'h5, "R9 lowest index wins");
    wr(5'h0C, 32'h20);
    rd_exp(5'h18, 32'h9, "R9 next index after ack");
    wr(5'h14, 32'h200);
    rd_exp(5'h04, 32'h0, "R8 pending masked");
    rd_exp(5'h00, 32'h200, "R8 status still set while disabled");
    rd_exp(5'h18, 32'hFFFF_FFFF, "R9 none pending all ones");

    cur_req = "R11";
    wr(5'h10, 32'h200);
    wr(5'h1C, 32'h2);
    idle(1);
    chk("R11 output needs bit 0", 32'(irq_out), 32'h0);
    wr(5'h1C, 32'h1);
    idle(1);
    chk("R11 output needs bit 1", 32'(irq_out), 32'h0);
    wr(5'h1C, 32'h3);
    idle(1);
    chk("R11 output high", 32'(irq_out), 32'h1);

    cur_req = "R2";
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h18, 32'h0);
    rd_exp(5'h00, 32'h200, "R2 status write ignored");
    wr(5'h0B, 32'h081); // low address bits ignored: enable
    rd_exp(5'h08, 32'h081, "R2 byte offset bits ignored");
    set_in(12'h000);
    wr(5'h0C, 32'hFFF);

    cur_req = "R12";
    set_in(12'hFFF);
    rd_exp(5'h00, 32'h0000_0FFF, "R12 upper status bits zero");
    set_in(12'h000);

    cur_req = "R2 random";
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #2;
      bus_addr  = 5'($urandom_range(0, 31));
      bus_we    = ($urandom_range(0, 2) == 0);
      bus_wdata = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      if ($urandom_range(0, 3) == 0) irq_in = N'($urandom);
    end
    @(posedge clk); #2;
    bus_we = 1'b0;
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule